// File: doc/BRIEF.md
# I2C Slave General-Call Decoder

This block sits behind the byte deserializer of an I2C slave and decides, one byte at a time, whether the slave should acknowledge a general-call sequence. The deserializer tells it when the first and the second byte after a START have arrived. It also supplies the received byte, the read/write bit and the bus START and STOP events. Three enables gate the decode: slave, general call and hardware general call. A programmable alternate ID names the hardware-call address that this device answers to.

For each byte strobe the block gives a registered acknowledge decision one cycle later. When a general-call sequence completes and is recognised, a sticky flag is raised with a 2-bit code that names the kind of call. The register interface clears the flag with a read strobe or a write-one-to-clear strobe. Clearing the slave enable puts the whole decoder back to its reset state.

Top module: `gc_decoder`

## Requirements
- R1: A first-byte strobe is acknowledged only when the address field rx_byte[7:1] is zero, rw_bit is 0 (write), and both the slave and general-call enables are high. Every other first byte is answered with ack = 0. rx_byte[0] plays no part in the first-byte decision.
- R2: After an acknowledged first byte, a second byte of 0x06 is acknowledged and raises the flag with gc_kind = 1 (reset). A second byte of 0x04 is acknowledged and raises the flag with gc_kind = 2 (write address).
- R3: A second byte with bit 0 set is a hardware call. It is acknowledged, and raises the flag with gc_kind = 3, only when the hardware-call enable and the general-call enable are high and the byte equals alt_id exactly. Otherwise it gets ack = 0 and no flag.
- R4: Any other second-byte value gets ack = 0 and no flag. After any second byte the decoder is idle, so a further second-byte strobe without a new acknowledged first byte gets ack = 0.
- R5: The flag rises only on the second byte, never on the first. While the flag is set, gc_kind holds the code of the latest recognised call. While the flag is clear, gc_kind is 0.
- R6: The flag stays set until flag_rd or flag_w1c is pulsed. If a new recognition arrives in the same cycle as a clear, the flag is set.
- R7: A start_seen or stop_seen pulse between the first and second byte aborts the sequence. The following second byte gets ack = 0 and no flag. A byte strobe in the same cycle as start_seen or stop_seen is ignored.
- R8: While slv_en is low, the flag and gc_kind are zero, no ack_vld is produced, and any partly decoded sequence is forgotten.
- R9: ack_vld pulses for exactly one cycle, one clock after each accepted byte strobe, and ack carries the decision in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slv_en | input | 1 | Slave enable; low clears the decoder |
| gc_en | input | 1 | General-call enable |
| hgc_en | input | 1 | Hardware-call enable |
| alt_id | input | 8 | Alternate ID matched by a hardware call |
| start_seen | input | 1 | START or repeated START observed on the bus |
| stop_seen | input | 1 | STOP observed on the bus |
| first_stb | input | 1 | First byte after START is on rx_byte |
| second_stb | input | 1 | Second byte after START is on rx_byte |
| rw_bit | input | 1 | Read/write bit of the first byte (1 = read) |
| rx_byte | input | 8 | Received byte |
| flag_rd | input | 1 | Clear-on-read strobe for the flag |
| flag_w1c | input | 1 | Write-one-to-clear strobe for the flag |
| ack_vld | output | 1 | Decision valid, one cycle after a strobe |
| ack | output | 1 | 1 = acknowledge, 0 = not acknowledge |
| gc_flag | output | 1 | Sticky general-call status flag |
| gc_kind | output | 2 | 0 none, 1 reset, 2 write address, 3 hardware |

## Verification
The decoder keeps two pieces of internal state: whether a sequence is armed, and the flag. If the armed state is wrong, it shows up at the next second-byte strobe. That strobe gets the wrong ack one cycle later, and the flag rises or fails to rise in the same cycle. If the flag or the kind is wrong, it is visible straight away and stays that way until a clear. So every scenario in the bench sends a second byte after the event under test, and reads the flag right after that byte's decision. The bench sends those second bytes after aborts, after bad values, after the slave enable is dropped and after a non-general-call first byte.

// File: rtl/gcd_pkg.sv
// Shared types for the general-call decoder.
// Assumes: 2-bit kind codes are visible at the top ports unchanged.
package gcd_pkg;
    typedef enum logic [1:0] {
        GC_NONE   = 2'd0,
        GC_RESET  = 2'd1,
        GC_WRADDR = 2'd2,
        GC_HW     = 2'd3
    } gc_kind_e;

    typedef enum logic {
        SQ_IDLE  = 1'b0,
        SQ_ARMED = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic     ack;
        gc_kind_e kind;
    } verdict_t;
endpackage

// File: rtl/gcd_first_check.sv
// Decides whether the first byte after START opens a general call.
// Assumes: addr_field is the 7-bit address, rw = 1 means read.
module gcd_first_check #(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W-1:0] addr_field,
    input  logic              rw,
    input  logic              slv_en,
    input  logic              gc_en,
    output logic              hit
);
    // General call: all-zero address, write direction, both enables on
    always_comb begin
        hit = slv_en && gc_en && (addr_field == '0) && !rw;
    end
endmodule

// File: rtl/gcd_second_classify.sv
// Classifies the second byte of a general call into a verdict.
// Assumes: only consulted while a sequence is armed.
module gcd_second_classify
    import gcd_pkg::*;
#(
    parameter int                DATA_W     = 8,
    parameter logic [DATA_W-1:0] RESET_CMD  = 8'h06,
    parameter logic [DATA_W-1:0] WRADDR_CMD = 8'h04
) (
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] alt_id,
    input  logic              gc_en,
    input  logic              hgc_en,
    output verdict_t          verdict
);
    // Bit 0 set selects hardware call, else software command lookup
    always_comb begin
        verdict.ack  = 1'b0;
        verdict.kind = GC_NONE;
        if (data[0]) begin
            if (hgc_en && gc_en && (data == alt_id)) begin
                verdict.ack  = 1'b1;
                verdict.kind = GC_HW;
            end
        end else if (data == RESET_CMD) begin
            verdict.ack  = 1'b1;
            verdict.kind = GC_RESET;
        end else if (data == WRADDR_CMD) begin
            verdict.ack  = 1'b1;
            verdict.kind = GC_WRADDR;
        end
    end
endmodule

// File: rtl/gcd_seq_fsm.sv
// Tracks the general-call sequence and registers the per-byte decision.
// Assumes: strobes are single-cycle; abort has priority over a strobe.
module gcd_seq_fsm
    import gcd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     slv_en,
    input  logic     first_stb,
    input  logic     second_stb,
    input  logic     abort,
    input  logic     first_hit,
    input  verdict_t verdict,
    output logic     ack_vld,
    output logic     ack,
    output logic     rec_stb,
    output gc_kind_e rec_kind
);
    seq_state_e state;

    // Recognition fires with the second byte of an armed sequence
    always_comb begin
        rec_stb  = second_stb && !abort && (state == SQ_ARMED) && verdict.ack;
        rec_kind = verdict.kind;
    end

    // Sequence state and registered acknowledge decision
    always_ff @(posedge clk) begin
        if (!rst_n || !slv_en) begin
            state   <= SQ_IDLE;
            ack_vld <= 1'b0;
            ack     <= 1'b0;
        end else begin
            ack_vld <= (first_stb || second_stb) && !abort;
            if (abort) begin
                state <= SQ_IDLE;
                ack   <= 1'b0;
            end else if (first_stb) begin
                ack   <= first_hit;
                state <= first_hit ? SQ_ARMED : SQ_IDLE;
            end else if (second_stb) begin
                ack   <= (state == SQ_ARMED) && verdict.ack;
                state <= SQ_IDLE;
            end
        end
    end

    // R9
    ack_vld_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld |-> $past(first_stb || second_stb));
    // R7
    abort_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (state == SQ_IDLE));
    // R4
    second_ends_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (second_stb && !abort) |=> (state == SQ_IDLE));
    // R1
    first_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (first_stb && !abort && !first_hit) |=> !ack);
endmodule

// File: rtl/gcd_status.sv
// Sticky general-call flag with kind code and two clear strobes.
// Assumes: set wins over clear in the same cycle.
module gcd_status
    import gcd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     slv_en,
    input  logic     set_stb,
    input  gc_kind_e set_kind,
    input  logic     clr_rd,
    input  logic     clr_w1c,
    output logic     flag,
    output gc_kind_e kind
);
    // Flag set on recognition, cleared by either strobe or disable
    always_ff @(posedge clk) begin
        if (!rst_n || !slv_en) begin
            flag <= 1'b0;
            kind <= GC_NONE;
        end else if (set_stb) begin
            flag <= 1'b1;
            kind <= set_kind;
        end else if (clr_rd || clr_w1c) begin
            flag <= 1'b0;
            kind <= GC_NONE;
        end
    end

    // R5
    kind_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag |-> (kind != GC_NONE));
    // R5
    kind_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag |-> (kind == GC_NONE));
    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && slv_en && !clr_rd && !clr_w1c) |=> flag);
    // R8
    disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slv_en |=> !flag);
endmodule

// File: rtl/gc_decoder.sv
// Top of the general-call decoder: per-byte ACK decision and sticky flag.
// Assumes: the deserializer gives one strobe per byte and separate
// START/STOP pulses; address of the first byte is rx_byte[7:1].
module gc_decoder
    import gcd_pkg::*;
#(
    parameter int                DATA_W     = 8,
    parameter logic [DATA_W-1:0] RESET_CMD  = 8'h06,
    parameter logic [DATA_W-1:0] WRADDR_CMD = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slv_en,
    input  logic              gc_en,
    input  logic              hgc_en,
    input  logic [DATA_W-1:0] alt_id,
    input  logic              start_seen,
    input  logic              stop_seen,
    input  logic              first_stb,
    input  logic              second_stb,
    input  logic              rw_bit,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              flag_rd,
    input  logic              flag_w1c,
    output logic              ack_vld,
    output logic              ack,
    output logic              gc_flag,
    output logic [1:0]        gc_kind
);
    localparam int ADDR_W = DATA_W - 1;

    logic     first_hit;
    logic     abort;
    logic     rec_stb;
    verdict_t verdict;
    gc_kind_e rec_kind;
    gc_kind_e kind_q;

    // Any bus boundary event cancels the sequence in progress
    always_comb abort = start_seen || stop_seen;

    gcd_first_check #(.ADDR_W(ADDR_W)) u_first (
        .addr_field (rx_byte[DATA_W-1:1]),
        .rw         (rw_bit),
        .slv_en     (slv_en),
        .gc_en      (gc_en),
        .hit        (first_hit)
    );

    gcd_second_classify #(
        .DATA_W     (DATA_W),
        .RESET_CMD  (RESET_CMD),
        .WRADDR_CMD (WRADDR_CMD)
    ) u_second (
        .data    (rx_byte),
        .alt_id  (alt_id),
        .gc_en   (gc_en),
        .hgc_en  (hgc_en),
        .verdict (verdict)
    );

    gcd_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .slv_en     (slv_en),
        .first_stb  (first_stb),
        .second_stb (second_stb),
        .abort      (abort),
        .first_hit  (first_hit),
        .verdict    (verdict),
        .ack_vld    (ack_vld),
        .ack        (ack),
        .rec_stb    (rec_stb),
        .rec_kind   (rec_kind)
    );

    gcd_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .slv_en   (slv_en),
        .set_stb  (rec_stb),
        .set_kind (rec_kind),
        .clr_rd   (flag_rd),
        .clr_w1c  (flag_w1c),
        .flag     (gc_flag),
        .kind     (kind_q)
    );

    // Present the kind code as a plain vector
    always_comb gc_kind = kind_q;
endmodule

// File: tb/tb_gc_decoder.sv
`timescale 1ns/1ps
module tb_gc_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slv_en = 1'b0, gc_en = 1'b0, hgc_en = 1'b0;
    logic [7:0] alt_id = 8'h00;
    logic       start_seen = 1'b0, stop_seen = 1'b0;
    logic       first_stb = 1'b0, second_stb = 1'b0, rw_bit = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       flag_rd = 1'b0, flag_w1c = 1'b0;
    logic       ack_vld, ack, gc_flag;
    logic [1:0] gc_kind;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  exp_q[$];
    string tag_q[$];
    bit  mon_on = 1'b0;

    always #4 clk = ~clk;

    gc_decoder dut (
        .clk(clk), .rst_n(rst_n), .slv_en(slv_en), .gc_en(gc_en),
        .hgc_en(hgc_en), .alt_id(alt_id), .start_seen(start_seen),
        .stop_seen(stop_seen), .first_stb(first_stb), .second_stb(second_stb),
        .rw_bit(rw_bit), .rx_byte(rx_byte), .flag_rd(flag_rd),
        .flag_w1c(flag_w1c), .ack_vld(ack_vld), .ack(ack),
        .gc_flag(gc_flag), .gc_kind(gc_kind)
    );

    // Monitor: pop one expected decision for every ack_vld seen
    always @(negedge clk) begin
        if (mon_on && ack_vld) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R9/R8 unexpected ack_vld: actual ack=%0b expected no decision", ack);
            end else begin
                bit    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (ack !== e) begin
                    n_fail++;
                    $display("FAIL %s ack: actual %0b expected %0b", t, ack, e);
                end
            end
        end
    end

    // Driver: one byte strobe; pushes expected decision when one is due
    task automatic send(input bit is_first, input logic [7:0] b, input bit rw,
                        input bit want_vld, input bit want_ack, input string tag);
        @(negedge clk);
        rx_byte    = b;
        rw_bit     = rw;
        first_stb  = is_first;
        second_stb = !is_first;
        if (want_vld) begin
            exp_q.push_back(want_ack);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        first_stb  = 1'b0;
        second_stb = 1'b0;
    endtask

    task automatic check_flag(input bit ef, input logic [1:0] ek, input string tag);
        n_tests++;
        if (gc_flag !== ef || gc_kind !== ek) begin
            n_fail++;
            $display("FAIL %s flag/kind: actual %0b/%0d expected %0b/%0d",
                     tag, gc_flag, gc_kind, ef, ek);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_rd;
        @(negedge clk); flag_rd = 1'b1;
        @(negedge clk); flag_rd = 1'b0;
    endtask

    task automatic pulse_w1c;
        @(negedge clk); flag_w1c = 1'b1;
        @(negedge clk); flag_w1c = 1'b0;
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_tests++;
        if (ack_vld !== 1'b0 || ack !== 1'b0) begin
            n_fail++;
            $display("FAIL reset ack_vld/ack: actual %0b/%0b expected 0/0", ack_vld, ack);
        end
        check_flag(0, 0, "reset");
        mon_on = 1'b1;
        slv_en = 1'b1; gc_en = 1'b1;

        // R1 / R2 reset command; R5 no flag after first byte
        send(1, 8'h00, 0, 1, 1, "R1 gc first byte");
        check_flag(0, 0, "R5 no flag after first byte");
        send(0, 8'h06, 0, 1, 1, "R2 reset cmd");
        check_flag(1, 1, "R2 reset kind");
        idle(3);
        check_flag(1, 1, "R6 sticky");
        pulse_rd();
        check_flag(0, 0, "R6 clear on read");

        // R2 write-address command, cleared by w1c
        send(1, 8'h00, 0, 1, 1, "R1 gc first byte");
        send(0, 8'h04, 0, 1, 1, "R2 write-address cmd");
        check_flag(1, 2, "R2 write-address kind");
        pulse_w1c();
        check_flag(0, 0, "R6 w1c clear");

        // R1 rejections; R4 second without armed
        send(1, 8'h00, 1, 1, 0, "R1 read direction");
        send(0, 8'h06, 0, 1, 0, "R4 second while idle");
        check_flag(0, 0, "R4 no flag idle");
        send(1, 8'hA0, 0, 1, 0, "R1 nonzero address");
        send(1, 8'h01, 0, 1, 1, "R1 rx_byte[0] ignored");
        send(0, 8'h22, 0, 1, 0, "R4 unlisted value");
        check_flag(0, 0, "R4 no flag unlisted");
        send(0, 8'h06, 0, 1, 0, "R4 idle after second");
        gc_en = 1'b0;
        send(1, 8'h00, 0, 1, 0, "R1 gc disabled");
        gc_en = 1'b1;

        // R3 hardware calls
        alt_id = 8'h35; hgc_en = 1'b1;
        send(1, 8'h00, 0, 1, 1, "R1 gc first byte");
        send(0, 8'h35, 0, 1, 1, "R3 hw match");
        check_flag(1, 3, "R3 hw kind");
        pulse_rd();
        send(1, 8'h00, 0, 1, 1, "R1 gc first byte");
        send(0, 8'h37, 0, 1, 0, "R3 hw mismatch");
        check_flag(0, 0, "R3 no flag mismatch");
        hgc_en = 1'b0;
        send(1, 8'h00, 0, 1, 1, "R1 gc first byte");
        send(0, 8'h35, 0, 1, 0, "R3 hw disabled");
        check_flag(0, 0, "R3 no flag disabled");

        // R7 aborts by STOP and by repeated START
        send(1, 8'h00, 0, 1, 1, "R1 gc first byte");
        @(negedge clk); stop_seen = 1'b1;
        @(negedge clk); stop_seen = 1'b0;
        send(0, 8'h06, 0, 1, 0, "R7 after stop");
        check_flag(0, 0, "R7 no flag stop");
        send(1, 8'h00, 0, 1, 1, "R1 gc first byte");
        @(negedge clk); start_seen = 1'b1;
        @(negedge clk); start_seen = 1'b0;
        send(0, 8'h04, 0, 1, 0, "R7 after restart");
        check_flag(0, 0, "R7 no flag restart");
        send(1, 8'h00, 0, 1, 1, "R1 gc first byte");
        @(negedge clk);
        rx_byte = 8'h06; second_stb = 1'b1; stop_seen = 1'b1;
        @(negedge clk);
        second_stb = 1'b0; stop_seen = 1'b0;
        check_flag(0, 0, "R7 strobe with stop ignored");

        // R6 set wins over clear in the same cycle
        send(1, 8'h00, 0, 1, 1, "R1 gc first byte");
        @(negedge clk);
        rx_byte = 8'h06; second_stb = 1'b1; flag_rd = 1'b1;
        exp_q.push_back(1'b1); tag_q.push_back("R6 set with clear ack");
        @(negedge clk);
        second_stb = 1'b0; flag_rd = 1'b0;
        check_flag(1, 1, "R6 set wins");

        // R8 slave disable clears flag and armed state
        slv_en = 1'b0;
        idle(1);
        check_flag(0, 0, "R8 disable clears flag");
        send(1, 8'h00, 0, 0, 0, "R8 no decision when off");
        slv_en = 1'b1;
        send(1, 8'h00, 0, 1, 1, "R1 gc first byte");
        slv_en = 1'b0;
        idle(1);
        slv_en = 1'b1;
        send(0, 8'h06, 0, 1, 0, "R8 armed state forgotten");
        check_flag(0, 0, "R8 no flag after re-enable");

        idle(3);
        n_tests++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R9 missing decisions: actual %0d pending expected 0", exp_q.size());
        end
        summary();
        $finish;
    end
endmodule